// File: doc/BRIEF.md
# Low-Power State Controller

This block decides whether a small processor system runs, idles or sleeps. A wait strobe from the CPU starts a low-power entry. The sleep-enable control bit chooses the target state. When the bit is clear, the controller enters Idle: the CPU is halted, but the system clock and the peripheral bus clock keep running. When the bit is set, it enters Sleep and gates both clocks off.

Interrupt requests are level-sensitive, and each one carries its own priority. Among the lines that are requesting, the highest priority is compared against the current CPU priority. Only a strictly greater priority brings the CPU back to Run. In Sleep, a request that fails this test still moves the device to Idle, which restarts the peripheral bus clock while the CPU stays halted. A watchdog timeout or a reset source also ends a low-power state.

Leaving Sleep passes through a wait state that holds the CPU halted until the clock-ready input reports that the oscillator and PLL are stable. Leaving Idle returns to Run at once. In Idle, each peripheral can be stopped on its own through its stop-in-idle bit.

Top module: `pwr_state_ctl`

## Requirements
- R1: While rst_n is low, and directly after it rises, state is RUN (code 0), cpu_halt is 0, sysclk_en and pbclk_en are 1, and every periph_run bit is 1.
- R2: In RUN, wait_stb with sleep_en=0 moves state to IDLE (code 1) on the next clock. In IDLE, cpu_halt=1, sysclk_en=1 and pbclk_en=1.
- R3: In RUN, wait_stb with sleep_en=1 moves state to SLEEP (code 2) on the next clock. In SLEEP, cpu_halt=1, sysclk_en=0, pbclk_en=0 and periph_run is all zero.
- R4: In IDLE, periph_run[i] is the inverse of stop_in_idle[i]. In RUN, every periph_run bit is 1 whatever stop_in_idle holds.
- R5: In IDLE, a request whose winning priority is strictly greater than cpu_prio returns state to RUN on the next clock, with no wait for clk_ready.
- R6: In IDLE, requests whose winning priority is lower than or equal to cpu_prio leave the state in IDLE.
- R7: In SLEEP, a winning priority above cpu_prio moves state to WAKE_WAIT (code 3). Any request that does not beat cpu_prio moves state to IDLE.
- R8: In WAKE_WAIT, cpu_halt stays 1 and both clock enables stay 0 while clk_ready is 0. The first clock with clk_ready=1 moves state to RUN.
- R9: wdt_timeout moves IDLE to RUN and moves SLEEP to WAKE_WAIT. It has no effect in RUN.
- R10: dev_reset forces state to RUN on the next clock from any state, ahead of every other input.
- R11: Only lines with irq_req[i]=1 count. The compared value is the largest irq_prio field (field i at bits i*PRIO_W and up) among those lines. Priorities on non-requesting lines are ignored.
- R12: wait_stb has no effect outside RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces RUN |
| wait_stb | input | 1 | Wait-instruction strobe from the CPU |
| sleep_en | input | 1 | 1 selects Sleep and 0 selects Idle on a wait strobe |
| irq_req | input | NUM_IRQ | Level-sensitive interrupt requests |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed priority of each request line |
| cpu_prio | input | PRIO_W | Current CPU priority |
| dev_reset | input | 1 | Synchronous reset source event |
| wdt_timeout | input | 1 | Watchdog timeout event |
| clk_ready | input | 1 | Oscillator start-up and PLL lock complete |
| stop_in_idle | input | NUM_PERIPH | Per-peripheral stop-in-idle bits |
| state | output | 2 | 0 RUN, 1 IDLE, 2 SLEEP, 3 WAKE_WAIT |
| cpu_halt | output | 1 | Holds the CPU halted |
| sysclk_en | output | 1 | System clock enable |
| pbclk_en | output | 1 | Peripheral bus clock enable |
| periph_run | output | NUM_PERIPH | Per-peripheral run enables |

## Verification
A wrong state register shows up on the state port and on the clock enables one clock after the input that caused it. The bench compares these outputs every cycle, so the cycle that goes wrong is reported. A wrong priority comparison has two visible signs. The device can leave Idle when it should stay. From Sleep, it can land in IDLE where WAKE_WAIT was expected, or the other way round. Both show at the next clock. A wrong wake path that skips the clock-ready wait releases cpu_halt early, and the bench detects this while clk_ready is still held low.

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int NUM_IRQ    = 4,
  parameter int PRIO_W     = 3,
  parameter int NUM_PERIPH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wait_stb,
  input  logic                      sleep_en,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         cpu_prio,
  input  logic                      dev_reset,
  input  logic                      wdt_timeout,
  input  logic                      clk_ready,
  input  logic [NUM_PERIPH-1:0]     stop_in_idle,
  output logic [1:0]                state,
  output logic                      cpu_halt,
  output logic                      sysclk_en,
  output logic                      pbclk_en,
  output logic [NUM_PERIPH-1:0]     periph_run
);
  localparam logic [1:0] ST_RUN   = 2'd0;
  localparam logic [1:0] ST_IDLE  = 2'd1;
  localparam logic [1:0] ST_SLEEP = 2'd2;
  localparam logic [1:0] ST_WAKE  = 2'd3;

  logic [1:0]        st, st_nx;
  logic [PRIO_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (irq_req[i] && irq_prio[i*PRIO_W +: PRIO_W] > best)
        best = irq_prio[i*PRIO_W +: PRIO_W];
  end

  wire any_req = |irq_req;
  wire wake_hi = any_req && (best > cpu_prio);

  always_comb begin
    st_nx = st;
    if (dev_reset) st_nx = ST_RUN;
    else begin
      case (st)
        ST_RUN:   if (wait_stb) st_nx = sleep_en ? ST_SLEEP : ST_IDLE;
        ST_IDLE:  if (wdt_timeout || wake_hi) st_nx = ST_RUN;
        ST_SLEEP: if (wdt_timeout || wake_hi) st_nx = ST_WAKE;
                  else if (any_req) st_nx = ST_IDLE;
        default:  if (clk_ready) st_nx = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_RUN;
    else        st <= st_nx;

  wire clocks_on = (st == ST_RUN) || (st == ST_IDLE);

  assign state      = st;
  assign cpu_halt   = (st != ST_RUN);
  assign sysclk_en  = clocks_on;
  assign pbclk_en   = clocks_on;
  assign periph_run = (st == ST_RUN)  ? {NUM_PERIPH{1'b1}} :
                      (st == ST_IDLE) ? ~stop_in_idle : '0;
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wait_stb,
  input logic                  sleep_en,
  input logic                  dev_reset,
  input logic                  wdt_timeout,
  input logic                  clk_ready,
  input logic [NUM_PERIPH-1:0] stop_in_idle,
  input logic [1:0]            state,
  input logic                  cpu_halt,
  input logic                  sysclk_en,
  input logic [NUM_PERIPH-1:0] periph_run
);
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 && wait_stb && !sleep_en && !dev_reset |=> state == 2'd1 && cpu_halt && sysclk_en);

  a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 && wait_stb && sleep_en && !dev_reset |=> state == 2'd2 && !sysclk_en);

  a_r4_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd1 |-> (periph_run & stop_in_idle) == '0);

  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd3 && !clk_ready && !dev_reset |=> state == 2'd3 && cpu_halt);

  a_r9_wdt_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd1 && wdt_timeout |=> !cpu_halt);

  a_r10_reset_source: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> state == 2'd0 && !cpu_halt);
endmodule

bind pwr_state_ctl pwr_state_ctl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .sleep_en(sleep_en),
  .dev_reset(dev_reset), .wdt_timeout(wdt_timeout), .clk_ready(clk_ready),
  .stop_in_idle(stop_in_idle), .state(state), .cpu_halt(cpu_halt),
  .sysclk_en(sysclk_en), .periph_run(periph_run)
);

// File: tb/pwr_state_ctl_tb.sv
module pwr_state_ctl_tb;
  localparam int NI = 4, PW = 3, NP = 4;

  logic clk = 0, rst_n = 0;
  logic wait_stb = 0, sleep_en = 0, dev_reset = 0, wdt_timeout = 0, clk_ready = 0;
  logic [NI-1:0] irq_req = '0;
  logic [NI*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_prio = '0;
  logic [NP-1:0] stop_in_idle = '0;
  logic [1:0] state;
  logic cpu_halt, sysclk_en, pbclk_en;
  logic [NP-1:0] periph_run;

  int checks = 0, fails = 0;
  logic [1:0] exp_st = 2'd0;

  always #5 clk = ~clk;

  pwr_state_ctl #(.NUM_IRQ(NI), .PRIO_W(PW), .NUM_PERIPH(NP)) u_dut (.*);

  function automatic logic [1:0] model(input logic [1:0] s);
    logic [PW-1:0] top;
    logic hi;
    top = '0;
    for (int i = 0; i < NI; i++)
      if (irq_req[i] && irq_prio[i*PW +: PW] > top) top = irq_prio[i*PW +: PW];
    hi = (irq_req != 0) && top > cpu_prio;
    if (dev_reset) return 2'd0;
    case (s)
      2'd0: return wait_stb ? (sleep_en ? 2'd2 : 2'd1) : 2'd0;
      2'd1: return (wdt_timeout || hi) ? 2'd0 : 2'd1;
      2'd2: return (wdt_timeout || hi) ? 2'd3 : (irq_req != 0) ? 2'd1 : 2'd2;
      default: return clk_ready ? 2'd0 : 2'd3;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string tag);
    logic on;
    logic [NP-1:0] pr;
    on = (exp_st == 2'd0) || (exp_st == 2'd1);
    pr = (exp_st == 2'd0) ? {NP{1'b1}} : (exp_st == 2'd1) ? ~stop_in_idle : '0;
    chk({tag, " state"}, 32'(state), 32'(exp_st));
    chk("R3 clocks", {cpu_halt, sysclk_en, pbclk_en}, {exp_st != 2'd0, on, on});
    chk("R4 periph_run", 32'(periph_run), 32'(pr));
  endtask

  task automatic step(input string tag);
    exp_st = model(exp_st);
    @(posedge clk);
    @(negedge clk);
    chk_out(tag);
  endtask

  task automatic quiet();
    wait_stb = 0; sleep_en = 0; irq_req = '0; dev_reset = 0; wdt_timeout = 0; clk_ready = 0;
  endtask

  function automatic logic [NI*PW-1:0] prios(input int a, b, c, d);
    return {PW'(d), PW'(c), PW'(b), PW'(a)};
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cpu_prio = 3'd3;
    stop_in_idle = 4'b0101;
    #23;
    exp_st = 2'd0;
    chk_out("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk_out("R1 after reset");

    wdt_timeout = 1; step("R9 wdt ignored in run");
    quiet(); wait_stb = 1; step("R2 idle entry");
    quiet(); chk("R4 idle mask", 32'(periph_run), 32'(4'b1010));
    wait_stb = 1; sleep_en = 1; step("R12 wait ignored in idle");
    quiet(); irq_req = 4'b0001; irq_prio = prios(3, 7, 0, 0);
    step("R6 equal prio stays idle");
    chk("R6 halt kept", 32'(cpu_halt), 32'd1);
    irq_req = 4'b0001; irq_prio = prios(2, 7, 7, 7);
    step("R11 masked lines ignored");
    irq_req = 4'b0011; step("R5 idle wake");
    chk("R5 running", 32'(cpu_halt), 32'd0);

    quiet(); wait_stb = 1; sleep_en = 1; step("R3 sleep entry");
    quiet(); irq_req = 4'b0100; irq_prio = prios(0, 0, 1, 0);
    step("R7 low prio sleep to idle");
    quiet(); wdt_timeout = 1; step("R9 wdt idle exit");

    quiet(); wait_stb = 1; sleep_en = 1; step("R3 sleep entry");
    quiet(); irq_req = 4'b1000; irq_prio = prios(0, 0, 0, 4);
    step("R7 high prio to wake wait");
    quiet();
    for (int k = 0; k < 3; k++) step("R8 waiting for clock");
    chk("R8 still halted", 32'(cpu_halt), 32'd1);
    clk_ready = 1; step("R8 ready releases");

    quiet(); wait_stb = 1; sleep_en = 1; step("R3 sleep entry");
    quiet(); wdt_timeout = 1; step("R9 wdt sleep exit");
    quiet(); dev_reset = 1; step("R10 reset from wake wait");
    quiet(); wait_stb = 1; step("R2 idle entry");
    quiet(); dev_reset = 1; wdt_timeout = 1; step("R10 reset from idle");

    for (int n = 0; n < 4000; n++) begin
      string tag;
      wait_stb     = ($urandom % 4) == 0;
      sleep_en     = $urandom % 2;
      irq_req      = (($urandom % 3) == 0) ? NI'($urandom) : '0;
      irq_prio     = (NI*PW)'($urandom);
      cpu_prio     = PW'($urandom);
      dev_reset    = ($urandom % 40) == 0;
      wdt_timeout  = ($urandom % 16) == 0;
      clk_ready    = ($urandom % 3) == 0;
      stop_in_idle = NP'($urandom);
      tag = dev_reset ? "R10" : (exp_st == 2'd0) ? "R2" : (exp_st == 2'd1) ? "R5" :
            (exp_st == 2'd2) ? "R7" : "R8";
      step(tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
  end
endmodule